// File: doc/BRIEF.md
# Staggered Multichannel Pulse-Density Threshold DAC

This block drives a bank of one-bit outputs, each of which an external two-stage RC filter turns into a DC threshold for a discriminator. Each channel stores a 16-bit setpoint and runs a first-order delta-sigma (carry-out) modulator. The output pin's duty cycle is proportional to the setpoint divided by 65536.

To keep switching noise low, a single slot counter walks through the channels in round-robin order. Only the channel that owns the current slot may advance its accumulator or change its pin. As a result, no two pins ever switch in the same clock cycle. With the default of 32 channels at 100 MHz, each channel updates at about 3.1 MHz.

Setpoints are loaded through a valid/ready write port. The block accepts a write in any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only while `rst` is asserted, so no back-pressure applies outside reset. A write presented during reset is not taken, and the source must hold it until `wr_ready` returns.

Top module: `stagger_pdm_dac`

## Requirements
- R1: While `rst` is high on a clock edge, that edge drives every bit of `dac_pin` low, clears every accumulator and returns the slot counter to channel 0. Reset is synchronous.
- R2: After reset is released, the first clock edge updates channel 0. Each following edge updates the next channel in ascending order, and the order wraps from channel NCH-1 back to 0.
- R3: On the edge that ends its slot, a channel computes the 17-bit sum of its 16-bit accumulator and its setpoint. The low 16 bits go back into the accumulator and bit 16 (the carry) becomes the channel's pin value. The pin holds that value until the channel's next slot.
- R4: Between any two consecutive clock edges outside reset, at most one bit of `dac_pin` changes.
- R5: A bit of `dac_pin` changes only on an edge that ends that channel's own slot. Each pin can therefore toggle at most once per NCH clock cycles.
- R6: A write replaces the setpoint of channel `wr_chan` (binary index, bits [4:0]) with `wr_value` at the accepting edge. The new value is first used at that channel's next slot after the write. If the write lands on the same edge as the channel's own slot, that update still uses the old setpoint. A write never clears the accumulator.
- R7: `wr_ready` is low exactly while `rst` is high. A write presented during reset has no effect.
- R8: A channel whose setpoint is 0 keeps its pin low.
- R9: With setpoint 0xFFFF loaded after reset, the channel's first update gives a low pin and the following updates give a high pin (one low in every 65536 updates).
- R10: Reset also returns every setpoint to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Setpoint write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_chan | input | 5 | Channel index of the write |
| wr_value | input | 16 | New setpoint |
| dac_pin | output | 32 | Pulse-density outputs, bit k belongs to channel k |

## Verification
A setpoint write and the modulator update of the same channel can fall on one clock edge. The bench provokes this by using its own slot model to aim writes at the channel whose slot is active in that cycle. The scoreboard expects the update on that edge to use the old setpoint and the following slot to use the new one, with the accumulator carried across unchanged. Reset and a write can also coincide. The bench drives a write during a mid-run reset and expects every pin to stay low afterwards.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  localparam int DEF_NCH = 32;
  localparam int DEF_DW  = 16;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pdm_slot_ring.sv
module pdm_slot_ring #(
  parameter int NCH = pdm_dac_pkg::DEF_NCH,
  parameter int SW  = pdm_dac_pkg::idx_bits(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [SW-1:0]  slot,
  output logic [NCH-1:0] slot_oh
);
  localparam logic [SW-1:0] LAST = SW'(NCH - 1);

  always_ff @(posedge clk) begin
    if (rst)               slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign slot_oh[g] = (slot == SW'(g));
  end
endmodule

// File: rtl/pdm_setpoint_bank.sv
module pdm_setpoint_bank #(
  parameter int NCH = pdm_dac_pkg::DEF_NCH,
  parameter int DW  = pdm_dac_pkg::DEF_DW,
  parameter int SW  = pdm_dac_pkg::idx_bits(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SW-1:0]     wchan,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] sp_flat
);
  for (genvar g = 0; g < NCH; g++) begin : g_sp
    logic [DW-1:0] sp_q;
    always_ff @(posedge clk) begin
      if (rst)                           sp_q <= '0;
      else if (we && wchan == SW'(g))    sp_q <= wdata;
    end
    assign sp_flat[g*DW +: DW] = sp_q;
  end
endmodule

// File: rtl/pdm_lane.sv
module pdm_lane #(
  parameter int DW = pdm_dac_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] sp,
  output logic          pin
);
  logic [DW-1:0] acc;
  logic [DW:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, sp};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      pin <= 1'b0;
    end else if (en) begin
      acc <= sum[DW-1:0];
      pin <= sum[DW];
    end
  end
endmodule

// File: rtl/stagger_pdm_dac.sv
module stagger_pdm_dac #(
  parameter int NCH = pdm_dac_pkg::DEF_NCH,
  parameter int DW  = pdm_dac_pkg::DEF_DW,
  parameter int SW  = pdm_dac_pkg::idx_bits(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [SW-1:0]  wr_chan,
  input  logic [DW-1:0]  wr_value,
  output logic [NCH-1:0] dac_pin
);
  logic [SW-1:0]     slot_idx;
  logic [NCH-1:0]    slot_oh;
  logic [NCH*DW-1:0] sp_flat;
  logic              wr_take;

  assign wr_ready = ~rst;
  assign wr_take  = wr_valid & wr_ready;

  pdm_slot_ring #(.NCH(NCH), .SW(SW)) u_ring (
    .clk(clk), .rst(rst), .slot(slot_idx), .slot_oh(slot_oh)
  );

  pdm_setpoint_bank #(.NCH(NCH), .DW(DW), .SW(SW)) u_bank (
    .clk(clk), .rst(rst), .we(wr_take), .wchan(wr_chan),
    .wdata(wr_value), .sp_flat(sp_flat)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    pdm_lane #(.DW(DW)) u_lane (
      .clk(clk), .rst(rst), .en(slot_oh[g]),
      .sp(sp_flat[g*DW +: DW]), .pin(dac_pin[g])
    );
  end
endmodule

// File: rtl/stagger_pdm_dac_chk.sv
module stagger_pdm_dac_chk #(
  parameter int NCH = pdm_dac_pkg::DEF_NCH,
  parameter int SW  = pdm_dac_pkg::idx_bits(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] dac_pin,
  input logic [SW-1:0]  slot
);
  logic armed = 1'b0;
  logic live  = 1'b0;

  always_ff @(posedge clk) begin
    armed <= armed | rst;
    live  <= armed & ~rst;
  end

  // R1
  a_r1_reset_low: assert property (@(posedge clk) rst |=> (dac_pin == '0));

  // R2
  a_r2_slot_advance: assert property (@(posedge clk) disable iff (rst)
    live |-> (slot == (($past(slot) == SW'(NCH - 1)) ? '0 : $past(slot) + 1'b1)));

  // R4
  a_r4_one_toggle: assert property (@(posedge clk) disable iff (rst)
    live |-> ($countones(dac_pin ^ $past(dac_pin)) <= 1));

  // R5
  a_r5_slot_owner: assert property (@(posedge clk) disable iff (rst)
    live |-> (((dac_pin ^ $past(dac_pin)) & ~(NCH'(1) << $past(slot))) == '0));
endmodule

bind stagger_pdm_dac stagger_pdm_dac_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .dac_pin(dac_pin), .slot(slot_idx)
);

// File: tb/stagger_pdm_dac_test.sv
`timescale 1ns/1ps
module stagger_pdm_dac_test;
  localparam int NCH = 32;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_valid = 1'b0;
  logic           wr_ready;
  logic [4:0]     wr_chan = '0;
  logic [DW-1:0]  wr_value = '0;
  logic [NCH-1:0] dac_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stagger_pdm_dac uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_value(wr_value), .dac_pin(dac_pin)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model and scoreboard
  typedef struct { logic [NCH-1:0] pins; logic upd; int slot; logic rst_edge; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0]  m_sp  [NCH];
  logic [DW-1:0]  m_acc [NCH];
  logic [NCH-1:0] m_pin = '0;
  int             m_slot = 0;

  always @(posedge clk) begin
    exp_t e;
    e.rst_edge = rst;
    e.upd = 1'b0;
    e.slot = m_slot;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin m_sp[i] = '0; m_acc[i] = '0; end
      m_pin = '0;
      m_slot = 0;
    end else begin
      logic [DW:0] s;
      s = {1'b0, m_acc[m_slot]} + {1'b0, m_sp[m_slot]};
      m_acc[m_slot] = s[DW-1:0];
      m_pin[m_slot] = s[DW];
      e.upd = 1'b1;
      m_slot = (m_slot + 1) % NCH;
      if (wr_valid) m_sp[wr_chan] = wr_value;
    end
    e.pins = m_pin;
    exp_q.push_back(e);
  end

  logic [NCH-1:0] prev_pin = '0;
  bit             have_prev = 1'b0;
  bit             ch3_went_high = 1'b0;
  bit             any_high = 1'b0;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R3 modulator pins", 64'(dac_pin), 64'(e.pins));
      check("R7 ready", 64'(wr_ready), 64'(!rst));
      if (e.rst_edge) begin
        check("R1 pins low after reset edge", 64'(dac_pin), 64'(0));
      end else if (have_prev) begin
        check("R4 single toggle", 64'($countones(dac_pin ^ prev_pin) <= 1), 64'(1));
        check("R5 toggle only in own slot (R2 order)",
              64'((dac_pin ^ prev_pin) & ~(NCH'(1) << e.slot)), 64'(0));
      end
      have_prev = !e.rst_edge;
      prev_pin = dac_pin;
      if (dac_pin[3]) ch3_went_high = 1'b1;
      if (dac_pin != '0) any_high = 1'b1;
    end
  end

  task automatic write(input int ch, input logic [DW-1:0] v);
    @(negedge clk);
    wr_valid = 1'b1; wr_chan = 5'(ch); wr_value = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;                 // R1 checked by monitor during reset
    write(5, 16'hFFFF);         // R9
    write(0, 16'h8000);
    write(1, 16'h4000);
    write(2, 16'hC000);
    write(31, 16'h0001);
    write(7, 16'h1234);
    write(3, 16'h0000);         // R8
    idle(2000);
    // R6: aim a write at the channel whose slot is active now
    @(negedge clk);
    while (m_slot != 9) @(negedge clk);
    wr_valid = 1'b1; wr_chan = 5'd9; wr_value = 16'hA000;
    @(negedge clk);
    wr_valid = 1'b0;
    idle(100);
    while (m_slot != 0) @(negedge clk);
    wr_valid = 1'b1; wr_chan = 5'd0; wr_value = 16'h2000;  // R6 no acc clear
    @(negedge clk);
    wr_valid = 1'b0;
    idle(2000);
    check("R9 full-scale channel high", 64'(dac_pin[5]), 64'(1));
    check("R8 zero setpoint never high", 64'(ch3_went_high), 64'(0));
    // R10 with write during reset (R7)
    rst = 1'b1;
    wr_valid = 1'b1; wr_chan = 5'd4; wr_value = 16'hF000;
    idle(2);
    check("R7 ready low in reset", 64'(wr_ready), 64'(0));
    wr_valid = 1'b0;
    rst = 1'b0;
    any_high = 1'b0;
    idle(200);
    check("R10 setpoints cleared by reset", 64'(any_high), 64'(0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule